// File: doc/BRIEF.md
# Power-Controller Serial Register Bank

This block is the two-wire serial slave of a power-management controller. It answers to one fixed 7-bit device address and gives a host write access to, and read access to, four 8-bit control registers. A write gives the register index and one data byte in a single transfer. A read first sets the index with a write-direction transfer that ends in STOP. A second transfer in the read direction then returns the byte, and the host ends it with NACK and STOP.

The register contents drive the rest of the chip as decoded control fields. These are a signed oscillator trim, an auxiliary-rail off flag, the linear-regulator voltage code, the oscillator and buck-converter enables, and the buck voltage code. There is also a select between a short and a long reset delay, and a slew select. A mode pin picks the active buck code. When the pin is high the normal-mode register supplies the code. When it is low the code comes from the low-power register. Both bus lines are synchronised to the system clock, and a counter filter rejects pulses shorter than 50 ns. The open-drain pad is modelled as a plain input and a pull-low enable.

Top module: `pmic_ctl_i2c`

## Requirements
- R1: After reset the registers hold index 0 = 0x00, index 1 = 0xD2, index 2 = 0xCF and index 3 = 0x0F, and these values appear both on the decoded outputs and in bus reads.
- R2: The block acknowledges an address byte only when its upper seven bits are 1101100. Bit 0 of that byte selects write (0) or read (1). Any other address gets no acknowledge, and a write that follows it changes nothing.
- R3: The write sequence START, address+W, index, data, STOP stores the data byte into the indexed register. Each of the three bytes is acknowledged.
- R4: After an index has been set, the sequence START, address+R returns that register's byte MSB first on SDA. The host ends it with NACK and STOP.
- R5: An index above 0x03 is still acknowledged. Writes to it leave all registers unchanged, and reads from it return 0x00.
- R6: The active buck code equals index 2 bits 5:0 while the mode pin `fullPwr` is 1, and equals index 3 bits 5:0 while it is 0.
- R7: The field layout is as follows. Index 0 is the trim. Index 1 has bit 7 = auxiliary off and bits 5:0 = linear-regulator code. Index 2 has bit 7 = oscillator on, bit 6 = buck on and bits 5:0 = normal buck code. Index 3 has bit 7 = long reset delay, bit 6 = slew select and bits 5:0 = low-power buck code.
- R8: A pulse on SCL or SDA shorter than 50 ns (5 cycles at 100 MHz) has no effect on the transfer.
- R9: The block pulls SDA low only after SCL has gone low: in an acknowledge slot or while it drives a read bit. It releases SDA on the next SCL fall.
- R10: Asserting the chip reset returns all registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls the data line low |
| fullPwr | input | 1 | Mode pin: 1 normal buck code, 0 low-power buck code |
| oscTrim | output | 8 | Two's-complement oscillator trim |
| auxOff | output | 1 | Auxiliary rail disable |
| ldoCode | output | 6 | Linear-regulator voltage code |
| oscOn | output | 1 | Oscillator enable |
| buckOn | output | 1 | Buck converter enable |
| buckCode | output | 6 | Active buck voltage code |
| delayLong | output | 1 | Long reset-delay select |
| slewSel | output | 1 | Slew-rate select |

## Verification
A bus line change reaches the control logic after two synchroniser flops and five filter cycles. The edge detector adds one more register. An acknowledge or read bit therefore appears on `sdaOe` about 8 cycles after the master moves SCL. The bench samples SDA half an SCL high phase (63 cycles) after the rising edge, well clear of that latency. A register write lands two cycles after the data byte's eighth SCL fall, so decoded outputs are checked only after STOP plus a few cycles. The buck-code select is combinational from the mode pin, and it is sampled one full clock after the pin moves, on a falling edge.

// File: rtl/pmic_ctl_pkg.sv
package pmic_ctl_pkg;

  localparam logic [6:0] DEV_ADDR = 7'b1101100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busSt_t;

  // strobes from bus control to register datapath
  typedef struct packed {
    logic       setPtr;
    logic       wrEn;
    logic [7:0] data;
  } regStrb_t;

  function automatic logic [7:0] regResetVal(input int idx);
    case (idx)
      1:       return 8'hD2;
      2:       return 8'hCF;
      3:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int CLK_MHZ   = 100,
  parameter int GLITCH_NS = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int FILT_CYC = (GLITCH_NS * CLK_MHZ + 999) / 1000;
  localparam int CNT_W    = $clog2(FILT_CYC + 1);

  logic             meta, syncV;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta     <= 1'b1;
      syncV    <= 1'b1;
      cleanOut <= 1'b1;
      cnt      <= '0;
    end else begin
      meta  <= rawIn;
      syncV <= meta;
      if (syncV == cleanOut) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FILT_CYC - 1)) begin
        cleanOut <= syncV;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: output only takes a value the synchronised input already held
  a_r8_filter_follows: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut != $past(cleanOut)) |-> ($past(syncV) == cleanOut));

endmodule

// File: rtl/pmic_bus_ctl.sv
module pmic_bus_ctl
  import pmic_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rdData,
  output regStrb_t   strb,
  output logic       sdaOe
);
  busSt_t     state;
  logic       sclQ, sdaQ, rnw;
  logic [3:0] bitCnt;
  logic [7:0] shReg;

  logic sclRise, sclFall, startC, stopC;
  assign sclRise = sclF & ~sclQ;
  assign sclFall = ~sclF & sclQ;
  assign startC  = sclF & sclQ & sdaQ & ~sdaF;
  assign stopC   = sclF & sclQ & ~sdaQ & sdaF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      state  <= ST_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
      rnw    <= 1'b0;
      sdaOe  <= 1'b0;
      strb   <= '0;
    end else begin
      sclQ        <= sclF;
      sdaQ        <= sdaF;
      strb.setPtr <= 1'b0;
      strb.wrEn   <= 1'b0;
      if (startC) begin
        state  <= ST_DEV;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopC) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_REG, ST_WR: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaF};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_DEV) begin
                if (shReg[7:1] == DEV_ADDR) begin
                  sdaOe <= 1'b1;
                  rnw   <= shReg[0];
                  state <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaOe       <= 1'b1;
                strb.data   <= shReg;
                strb.setPtr <= (state == ST_REG);
                strb.wrEn   <= (state == ST_WR);
                state       <= (state == ST_REG) ? ST_REG_ACK : ST_WR_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (sclFall) begin
              if (rnw) begin
                shReg  <= rdData;
                sdaOe  <= ~rdData[7];
                bitCnt <= '0;
                state  <= ST_RD;
              end else begin
                sdaOe <= 1'b0;
                state <= ST_REG;
              end
            end
          end
          ST_REG_ACK, ST_WR_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              state <= ST_WR;
            end
          end
          ST_RD: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe  <= 1'b0;
                bitCnt <= '0;
                state  <= ST_RD_ACK;
              end else begin
                sdaOe <= ~shReg[6];
                shReg <= {shReg[6:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise && sdaF) begin
              state <= ST_IDLE;
            end else if (sclFall) begin
              shReg <= rdData;
              sdaOe <= ~rdData[7];
              state <= ST_RD;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: pull-low only in an acknowledge slot or a read-data slot
  a_r9_oe_slot: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state inside {ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK, ST_RD}));

  // R9: pull-low starts only while the filtered clock is low
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclF);

  // R2: never both strobes at once
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setPtr && strb.wrEn));

endmodule

// File: rtl/pmic_reg_dp.sv
module pmic_reg_dp
  import pmic_ctl_pkg::*;
#(
  parameter int REG_NUM = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  regStrb_t   strb,
  input  logic       fullPwr,
  output logic [7:0] rdData,
  output logic [7:0] oscTrim,
  output logic       auxOff,
  output logic [5:0] ldoCode,
  output logic       oscOn,
  output logic       buckOn,
  output logic [5:0] buckCode,
  output logic       delayLong,
  output logic       slewSel
);
  localparam int         IDX_W   = $clog2(REG_NUM);
  localparam logic [7:0] REG_LIM = 8'(REG_NUM);

  logic [REG_NUM-1:0][7:0] regs;
  logic [7:0]              ptr;
  logic                    ptrOk;

  assign ptrOk = (ptr < REG_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < REG_NUM; i++) regs[i] <= regResetVal(i);
    end else begin
      if (strb.setPtr) ptr <= strb.data;
      if (strb.wrEn && ptrOk) regs[ptr[IDX_W-1:0]] <= strb.data;
    end
  end

  assign rdData    = ptrOk ? regs[ptr[IDX_W-1:0]] : 8'h00;
  assign oscTrim   = regs[0];
  assign auxOff    = regs[1][7];
  assign ldoCode   = regs[1][5:0];
  assign oscOn     = regs[2][7];
  assign buckOn    = regs[2][6];
  assign delayLong = regs[3][7];
  assign slewSel   = regs[3][6];
  assign buckCode  = fullPwr ? regs[2][5:0] : regs[3][5:0];

  // R3: registers move only on a write strobe
  a_r3_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(regs));

  // R5: out-of-range writes leave the bank untouched
  a_r5_oob_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !ptrOk) |=> $stable(regs));

endmodule

// File: rtl/pmic_ctl_i2c.sv
module pmic_ctl_i2c
  import pmic_ctl_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int GLITCH_NS = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       fullPwr,
  output logic [7:0] oscTrim,
  output logic       auxOff,
  output logic [5:0] ldoCode,
  output logic       oscOn,
  output logic       buckOn,
  output logic [5:0] buckCode,
  output logic       delayLong,
  output logic       slewSel
);
  logic [1:0] rawLines, cleanLines;
  regStrb_t   strb;
  logic [7:0] rdData;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    line_filter #(.CLK_MHZ(CLK_MHZ), .GLITCH_NS(GLITCH_NS)) i_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g]));
  end

  pmic_bus_ctl i_ctl (
    .clk(clk), .rstN(rstN), .sclF(cleanLines[0]), .sdaF(cleanLines[1]),
    .rdData(rdData), .strb(strb), .sdaOe(sdaOe));

  pmic_reg_dp #(.REG_NUM(4)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fullPwr(fullPwr), .rdData(rdData),
    .oscTrim(oscTrim), .auxOff(auxOff), .ldoCode(ldoCode), .oscOn(oscOn),
    .buckOn(buckOn), .buckCode(buckCode), .delayLong(delayLong),
    .slewSel(slewSel));

endmodule

// File: tb/test_pmic_ctl_i2c.sv
module test_pmic_ctl_i2c;
  localparam int Q = 63;
  localparam logic [6:0] DEV = 7'b1101100;

  logic clk = 1'b0, rstN = 1'b0, sclMst = 1'b1, sdaMst = 1'b1, fullPwr = 1'b1;
  logic sdaOe, sdaLine, auxOff, oscOn, buckOn, delayLong, slewSel;
  logic [7:0] oscTrim;
  logic [5:0] ldoCode, buckCode;
  int checks = 0, failures = 0;
  bit finished = 0;

  assign sdaLine = sdaMst & ~sdaOe;
  always #5 clk = ~clk;

  pmic_ctl_i2c i_pmic_ctl_i2c (
    .clk(clk), .rstN(rstN), .sclIn(sclMst), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .fullPwr(fullPwr), .oscTrim(oscTrim), .auxOff(auxOff), .ldoCode(ldoCode),
    .oscOn(oscOn), .buckOn(buckOn), .buckCode(buckCode),
    .delayLong(delayLong), .slewSel(slewSel));

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaMst = 1'b1; sclMst = 1'b1; waitc(Q);
    sdaMst = 1'b0; waitc(Q);
    sclMst = 1'b0; waitc(Q);
  endtask

  task automatic busStop();
    sdaMst = 1'b0; waitc(Q);
    sclMst = 1'b1; waitc(Q);
    sdaMst = 1'b1; waitc(2 * Q);
  endtask

  task automatic sendBit(input logic b, input bit glitch);
    sdaMst = b;
    if (glitch) begin
      waitc(20); sclMst = 1'b1; waitc(4); sclMst = 1'b0; waitc(Q - 24);
    end else waitc(Q);
    sclMst = 1'b1; waitc(2 * Q);
    sclMst = 1'b0; waitc(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaMst = 1'b1; waitc(Q);
    sclMst = 1'b1; waitc(Q);
    b = sdaLine; waitc(Q);
    sclMst = 1'b0; waitc(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, input bit glitch, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i], glitch && (i == 3));
    recvBit(a);
    ack = !a;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); d[i] = b; end
    sendBit(nack, 1'b0);
  endtask

  task automatic regWrite(input logic [6:0] dev, input logic [7:0] ra,
                          input logic [7:0] d, input bit glitch, output bit ok);
    bit a0, a1, a2;
    busStart();
    sendByte({dev, 1'b0}, 1'b0, a0);
    a1 = 0; a2 = 0;
    if (a0) begin
      sendByte(ra, 1'b0, a1);
      sendByte(d, glitch, a2);
    end
    busStop();
    waitc(4);
    ok = a0 && a1 && a2;
  endtask

  task automatic regRead(input logic [7:0] ra, output logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    busStart();
    sendByte({DEV, 1'b0}, 1'b0, a0);
    sendByte(ra, 1'b0, a1);
    busStop();
    busStart();
    sendByte({DEV, 1'b1}, 1'b0, a2);
    recvByte(d, 1'b1);
    busStop();
    ok = a0 && a1 && a2;
  endtask

  task automatic testResetState();
    check("R1 oscTrim", oscTrim, 8'h00);
    check("R1 auxOff/ldoCode", {auxOff, ldoCode}, {1'b1, 6'h12});
    check("R1 oscOn/buckOn/buckCode", {oscOn, buckOn, buckCode}, {2'b11, 6'h0F});
    check("R1 delayLong/slewSel", {delayLong, slewSel}, 2'b00);
    check("R9 sdaOe idle", sdaOe, 1'b0);
  endtask

  task automatic testResetReads();
    logic [7:0] d; bit ok;
    for (int i = 0; i < 4; i++) begin
      regRead(8'(i), d, ok);
      check("R2 R4 read acks", ok, 1'b1);
      check("R1 R4 read value", d, (i == 1) ? 8'hD2 : (i == 2) ? 8'hCF : (i == 3) ? 8'h0F : 8'h00);
    end
  endtask

  task automatic testWrites();
    logic [7:0] d; bit ok;
    regWrite(DEV, 8'h00, 8'h85, 1'b0, ok);
    check("R3 write acks", ok, 1'b1);
    check("R3 R7 trim field", oscTrim, 8'h85);
    regRead(8'h00, d, ok);
    check("R4 readback", d, 8'h85);
    regWrite(DEV, 8'h01, 8'h3C, 1'b0, ok);
    check("R7 aux/ldo fields", {auxOff, ldoCode}, {1'b0, 6'h3C});
    regWrite(DEV, 8'h02, 8'h25, 1'b0, ok);
    check("R7 osc/buck fields", {oscOn, buckOn, buckCode}, {2'b00, 6'h25});
    regWrite(DEV, 8'h03, 8'hC7, 1'b0, ok);
    check("R7 delay/slew fields", {delayLong, slewSel}, 2'b11);
  endtask

  task automatic testModePin();
    fullPwr = 1'b0; waitc(1);
    check("R6 low-power code", buckCode, 6'h07);
    fullPwr = 1'b1; waitc(1);
    check("R6 normal code", buckCode, 6'h25);
  endtask

  task automatic testWrongAddr();
    bit ok;
    regWrite(7'b0101010, 8'h00, 8'h11, 1'b0, ok);
    check("R2 foreign address no ack", ok, 1'b0);
    check("R2 foreign write ignored", oscTrim, 8'h85);
  endtask

  task automatic testOutOfRange();
    logic [7:0] d; bit ok;
    regWrite(DEV, 8'h07, 8'hFF, 1'b0, ok);
    check("R5 high index acked", ok, 1'b1);
    check("R5 bank unchanged", {oscTrim, auxOff, ldoCode, oscOn, buckOn, buckCode, delayLong, slewSel},
          {8'h85, 1'b0, 6'h3C, 2'b00, 6'h25, 2'b11});
    regRead(8'h07, d, ok);
    check("R5 high index reads zero", d, 8'h00);
  endtask

  task automatic testGlitch();
    logic [7:0] d; bit ok;
    regWrite(DEV, 8'h00, 8'h5A, 1'b1, ok);
    check("R8 glitch write acks", ok, 1'b1);
    regRead(8'h00, d, ok);
    check("R8 glitch suppressed", d, 8'h5A);
  endtask

  task automatic testReset();
    rstN = 1'b0; waitc(3);
    rstN = 1'b1; waitc(3);
    check("R10 trim back", oscTrim, 8'h00);
    check("R10 fields back", {auxOff, ldoCode, oscOn, buckOn, buckCode, delayLong, slewSel},
          {1'b1, 6'h12, 2'b11, 6'h0F, 2'b00});
  endtask

  initial begin
    waitc(5);
    rstN = 1'b1;
    waitc(5);
    testResetState();
    testResetReads();
    testWrites();
    testModePin();
    testWrongAddr();
    testOutOfRange();
    testGlitch();
    testReset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule